// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the byte a host gets back when it reads a flash device. While a program or erase operation runs, it returns a status byte instead of array contents. The status byte carries a polling bit that resolves to the true data once the operation ends. It also carries a bit that flips on every read, a sticky time-limit flag, the phase that ran out of time, and an indication that the sector-erase collection window has closed. When no operation is running and no time-limit fault is pending, the array byte on `arr_rdata` passes straight through.

Read requests arrive on a valid/ready port. The array byte is presented together with the request. Each accepted request produces one response beat, held in an output register. A request is accepted when `rd_req_valid` is high and `rd_req_ready` is high. `rd_req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response word and `rsp_valid` stay frozen and no new request is taken. The operation engine drives the busy, phase, programmed-MSB, timeout and window inputs as plain level signals. A single-cycle `clr_cmd` pulse stands for the reset command written by software.

Top module: `opst_status_gen`

## Requirements
- R1: When `eng_busy` is low and no fault is latched, an accepted read returns `arr_rdata` unchanged, one cycle after acceptance.
- R2: During a program operation (`eng_erase`=0), bit 7 of the returned byte is the inverse of `prog_msb`.
- R3: During an erase operation (`eng_erase`=1), bit 7 of the returned byte is 0.
- R4: Bit 6 returns an internal toggle. The toggle flips after each accepted read while an operation or fault is active and holds on cycles with no accepted read. It is 0 whenever the block is inactive, so the first status read of each operation returns 0 in bit 6.
- R5: An `eng_timeout` pulse while `eng_busy` is high latches a fault. The fault keeps status mode active, with bit 5 = 1, even after `eng_busy` falls, until a `clr_cmd` pulse clears it. `clr_cmd` wins over a simultaneous timeout.
- R6: Bit 4 is 1 only when a fault is latched and the failing phase was erase; otherwise it is 0. The phase is captured when the fault is latched.
- R7: Bit 3 is 1 when the current phase is erase and `win_open` is low; otherwise it is 0.
- R8: Bits 2 to 0 of any status byte are 0.
- R9: `rd_req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.
- R10: After reset, `rsp_valid` is 0, no fault is latched and the toggle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request can be taken |
| arr_rdata | input | DATA_W | Array byte for the current request |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Array byte or status byte |
| eng_busy | input | 1 | Operation engine running |
| eng_erase | input | 1 | 1 = erase phase, 0 = program phase |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| eng_timeout | input | 1 | Engine reports time limit exceeded |
| win_open | input | 1 | Sector-erase collection window still open |
| clr_cmd | input | 1 | Reset command pulse |

## Verification
The hardest state to reach is a latched fault that outlives the engine's busy signal. The timeout pulse has to land while busy is high, and busy must then drop, so the bench checks that status mode persists until the clear command. Another awkward point is where the toggle phase meets back-pressure: a stalled response must not advance the toggle. The bench reaches both through directed sequences and then through a long random run with rare timeout and clear pulses. In the random run, an independent model is compared against the outputs on every cycle.

// File: rtl/opst_pkg.sv
package opst_pkg;
  typedef enum logic {
    PH_PROG  = 1'b0,
    PH_ERASE = 1'b1
  } phase_e;

  // fixed positions of the status flags in the returned byte
  localparam int POS_POLL = 7;
  localparam int POS_TGL  = 6;
  localparam int POS_TMO  = 5;
  localparam int POS_PH   = 4;
  localparam int POS_WIN  = 3;
  localparam int STAT_W   = 8;
endpackage

// File: rtl/opst_toggle.sv
module opst_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rd_fire,
  output logic tgl
);
  always_ff @(posedge clk) begin
    if (!rst_n)        tgl <= 1'b0;
    else if (!active)  tgl <= 1'b0;
    else if (rd_fire)  tgl <= ~tgl;
  end

  // R4
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && rd_fire |=> tgl != $past(tgl));
  // R4
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !rd_fire |=> $stable(tgl));
  // R4
  tgl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !tgl);
endmodule

// File: rtl/opst_fault.sv
module opst_fault
  import opst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   busy,
  input  phase_e phase_in,
  input  logic   timeout,
  input  logic   clr,
  output logic   fault,
  output phase_e fault_phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault       <= 1'b0;
      fault_phase <= PH_PROG;
    end else if (clr) begin
      fault       <= 1'b0;
    end else if (timeout && busy) begin
      fault       <= 1'b1;
      fault_phase <= phase_in;
    end
  end

  // R5
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clr |=> fault);
  // R5
  fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fault);
  // R6
  fault_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && busy && !clr |=> fault && fault_phase == $past(phase_in));
endmodule

// File: rtl/opst_compose.sv
module opst_compose
  import opst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busy,
  input  logic              fault,
  input  phase_e            eng_phase,
  input  phase_e            fault_phase,
  input  logic              prog_msb,
  input  logic              win_open,
  input  logic              tgl,
  input  logic [DATA_W-1:0] arr_data,
  output logic              active,
  output logic [DATA_W-1:0] word
);
  phase_e phase;

  always_comb begin
    phase  = fault ? fault_phase : eng_phase;
    active = busy | fault;
    if (!active) begin
      word = arr_data;
    end else begin
      word           = '0;
      word[POS_POLL] = (phase == PH_PROG) ? ~prog_msb : 1'b0;
      word[POS_TGL]  = tgl;
      word[POS_TMO]  = fault;
      word[POS_PH]   = fault & (phase == PH_ERASE);
      word[POS_WIN]  = (phase == PH_ERASE) & ~win_open;
    end
  end
endmodule

// File: rtl/opst_status_gen.sv
module opst_status_gen
  import opst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              eng_busy,
  input  logic              eng_erase,
  input  logic              prog_msb,
  input  logic              eng_timeout,
  input  logic              win_open,
  input  logic              clr_cmd
);
  localparam int LOW_W = POS_WIN;

  logic              fire;
  logic              active;
  logic              tgl;
  logic              fault;
  phase_e            fault_phase;
  phase_e            eng_phase;
  logic [DATA_W-1:0] word;

  assign eng_phase    = eng_erase ? PH_ERASE : PH_PROG;
  assign rd_req_ready = !rsp_valid || rsp_ready;
  assign fire         = rd_req_valid && rd_req_ready;

  opst_toggle u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .rd_fire (fire),
    .tgl     (tgl)
  );

  opst_fault u_fault (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (eng_busy),
    .phase_in    (eng_phase),
    .timeout     (eng_timeout),
    .clr         (clr_cmd),
    .fault       (fault),
    .fault_phase (fault_phase)
  );

  opst_compose #(.DATA_W(DATA_W)) u_comp (
    .busy        (eng_busy),
    .fault       (fault),
    .eng_phase   (eng_phase),
    .fault_phase (fault_phase),
    .prog_msb    (prog_msb),
    .win_open    (win_open),
    .tgl         (tgl),
    .arr_data    (arr_rdata),
    .active      (active),
    .word        (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R1
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !eng_busy && !fault |=> rsp_data == $past(arr_rdata));
  // R8
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (eng_busy || fault) |=> rsp_data[LOW_W-1:0] == '0);
  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && eng_busy && eng_erase && !fault |=> !rsp_data[POS_POLL]);
  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && eng_busy && !eng_erase && !fault |=> rsp_data[POS_POLL] == !$past(prog_msb));
  // R5
  tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && fault |=> rsp_data[POS_TMO]);
endmodule

// File: tb/tb_opst_status_gen.sv
`timescale 1ns/1ps
module tb_opst_status_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_req_valid = 1'b0;
  logic       rd_req_ready;
  logic [7:0] arr_rdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       eng_busy = 1'b0, eng_erase = 1'b0, prog_msb = 1'b0;
  logic       eng_timeout = 1'b0, win_open = 1'b0, clr_cmd = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opst_status_gen #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .arr_rdata(arr_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .eng_busy(eng_busy), .eng_erase(eng_erase), .prog_msb(prog_msb),
    .eng_timeout(eng_timeout), .win_open(win_open), .clr_cmd(clr_cmd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit       m_valid, m_fault, m_fph, m_tgl, m_rdy, m_fire, m_act, m_ph;
  bit [7:0] m_data, m_sb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_data = 0; m_fault = 0; m_fph = 0; m_tgl = 0;
    end else begin
      m_rdy  = !m_valid || rsp_ready;
      m_fire = rd_req_valid && m_rdy;
      m_act  = eng_busy || m_fault;
      m_ph   = m_fault ? m_fph : eng_erase;
      if (m_fire) begin
        if (!m_act) m_sb = arr_rdata;
        else begin
          m_sb = 8'h00;
          m_sb[7] = m_ph ? 1'b0 : !prog_msb;
          m_sb[6] = m_tgl;
          m_sb[5] = m_fault;
          m_sb[4] = m_fault && m_ph;
          m_sb[3] = m_ph && !win_open;
        end
        m_valid = 1; m_data = m_sb;
      end else if (rsp_ready) m_valid = 0;
      m_tgl = !m_act ? 1'b0 : (m_fire ? !m_tgl : m_tgl);
      if (clr_cmd) m_fault = 0;
      else if (eng_timeout && eng_busy) begin m_fault = 1; m_fph = eng_erase; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rsp_valid == m_valid, "R9 model valid", rsp_valid, m_valid);
      chk(rd_req_ready == (!m_valid || rsp_ready), "R9 model ready", rd_req_ready, !m_valid || rsp_ready);
      if (m_valid) chk(rsp_data == m_data, "R1-model data", rsp_data, m_data);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_read(input logic [7:0] arr, input logic [7:0] exp, input string tag);
    rd_req_valid = 1; arr_rdata = arr;
    step();
    rd_req_valid = 0;
    chk(rsp_valid && rsp_data == exp, tag, rsp_data, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(2);
    // R10 reset state
    chk(rsp_valid == 0, "R10 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    step();
    chk(rsp_valid == 0 && rd_req_ready == 1, "R10 after reset", rsp_valid, 0);

    do_read(8'h5A, 8'h5A, "R1 idle passthrough");

    eng_busy = 1; eng_erase = 0; prog_msb = 1;
    step(3);
    do_read(8'hFF, 8'h00, "R2 R4 R8 first program read");
    do_read(8'hFF, 8'h40, "R4 toggle flips");
    prog_msb = 0;
    step(4);
    do_read(8'hFF, 8'h80, "R2 complement bit7, R4 held between reads");
    eng_busy = 0;
    step();
    do_read(8'h3C, 8'h3C, "R1 back to array data");

    eng_busy = 1; eng_erase = 1; win_open = 1;
    do_read(8'hFF, 8'h00, "R3 erase bit7 low, R4 restart");
    do_read(8'hFF, 8'h40, "R4 erase toggle");
    win_open = 0;
    do_read(8'hFF, 8'h08, "R7 window closed");
    eng_timeout = 1; step(); eng_timeout = 0; eng_busy = 0;
    do_read(8'hFF, 8'h78, "R5 R6 erase timeout flags");
    step(5);
    do_read(8'hFF, 8'h38, "R5 fault sticky after busy drop");
    clr_cmd = 1; step(); clr_cmd = 0;
    do_read(8'h11, 8'h11, "R5 clear restores array read");

    eng_busy = 1; eng_erase = 0; prog_msb = 1;
    step();
    eng_timeout = 1; clr_cmd = 1; step(); eng_timeout = 0; clr_cmd = 0;
    eng_busy = 0;
    do_read(8'h66, 8'h66, "R5 clear wins over timeout");
    eng_busy = 1;
    eng_timeout = 1; step(); eng_timeout = 0; eng_busy = 0;
    do_read(8'hFF, 8'h20, "R6 program timeout phase 0");
    clr_cmd = 1; step(); clr_cmd = 0;

    rsp_ready = 0;
    do_read(8'h99, 8'h99, "R9 first beat");
    rd_req_valid = 1; arr_rdata = 8'h22;
    chk(rd_req_ready == 0, "R9 ready low when stalled", rd_req_ready, 0);
    step(2);
    chk(rsp_valid && rsp_data == 8'h99, "R9 held under backpressure", rsp_data, 8'h99);
    rsp_ready = 1;
    step();
    rd_req_valid = 0;
    chk(rsp_valid && rsp_data == 8'h22, "R9 next beat after drain", rsp_data, 8'h22);
    step(2);

    for (int i = 0; i < 4000; i++) begin
      rd_req_valid = ($urandom % 3) != 0;
      rsp_ready    = ($urandom % 4) != 0;
      arr_rdata    = 8'($urandom);
      if ($urandom % 16 == 0) eng_busy = !eng_busy;
      if ($urandom % 32 == 0) eng_erase = !eng_erase;
      prog_msb     = 1'($urandom);
      win_open     = ($urandom % 8) != 0;
      eng_timeout  = ($urandom % 60) == 0;
      clr_cmd      = ($urandom % 50) == 0;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule